// File: doc/BRIEF.md
# E1 CAS Signaling Engine

This block carries channel-associated signaling for one 30-channel E1 port. It holds two stores of sixteen 8-bit signaling registers: one feeds the transmit direction and one records what arrives on the receive direction. Each store entry belongs to one frame of the 16-frame multiframe. Entry index k, at register address k, serves frame k. Entry 0 carries the multiframe alignment nibble. Entries 1 to 15 each carry the A,B,C,D bits of two channels: channel k in bits 7:4 and channel k+15 in bits 3:0.

Both line directions are byte streams, one beat per time slot. Each beat carries frame-start and multiframe-start marker bits beside the data. The transmit stream passes through without storage: its ready follows the downstream ready and its valid follows the upstream valid. When insertion is enabled, the engine replaces the time slot 16 byte with the transmit entry for the current frame. The receive stream is never held off. Its time slot 16 byte is written into the receive store, and a change-of-signaling flag is raised at the end of any multiframe in which a signaling byte differed from the one before it.

A small register port writes the transmit store and the control byte, reads either store, and reads a status bit. That status bit is shared between the signaling change flag and an external transmit-clock alarm input.

Top module: `e1cas_engine`

## Requirements
- R1: A register write to address k (0 to 15) always lands in transmit entry k, whatever the control bit `rd_tx` (control bit 0) holds. With `rd_tx`=1, a read of address k returns transmit entry k. A write with `rd_tx`=0 leaves the receive entry at that address unchanged.
- R2: Transmit entry 0 keeps bits 7:4 at zero: a written value is stored with its upper nibble cleared.
- R3: With `rd_tx`=0, a read of address k (0 to 15) returns receive entry k.
- R4: With insert enable (control bit 1) set, the accepted transmit beat at time slot 16 of frame f leaves as transmit entry f. Beats in every other slot leave unchanged.
- R5: With insert enable clear, every transmit beat leaves unchanged.
- R6: The slot position runs 0 to 31 and the frame position runs 0 to 15, advancing once per accepted beat. A beat with the multiframe marker set is slot 0 of frame 0. A beat with only the frame marker set is slot 0, and it advances the frame when it arrives before slot 31 was reached.
- R7: An accepted receive beat at slot 16 of frame f is stored as receive entry f.
- R8: The change flag sets on the accepted receive beat at slot 31 of frame 15, if any captured byte of frames 1 to 15 in that multiframe differed from the entry it replaced. A change only in frame 0 does not set it.
- R9: Status address 17, bit 0, and the `sig_status` pin show the change flag when control bit 2 is 1, and the input `tx_clk_alarm` when it is 0.
- R10: Writing status address 17 with bit 0 = 1 clears the change flag.
- R11: Reset clears both stores, the control byte and the change flag. A register write of control address 16 with bit 7 = 1 is a 0-to-1 transition of the software reset bit, which always reads back 0, and it clears the same state.
- R12: `tx_in_ready` equals `tx_out_ready` and `tx_out_valid` equals `tx_in_valid`. A beat is accepted only when valid and ready are both high. `rx_in_ready` is always 1. Position counters hold while no beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_in_valid | input | 1 | Transmit beat offered |
| tx_in_ready | output | 1 | Transmit beat taken |
| tx_in_data | input | 8 | Transmit slot byte |
| tx_in_fas | input | 1 | Beat is slot 0 of a frame |
| tx_in_mfas | input | 1 | Beat is slot 0 of frame 0 |
| tx_out_valid | output | 1 | Outgoing transmit beat valid |
| tx_out_ready | input | 1 | Downstream can take a beat |
| tx_out_data | output | 8 | Outgoing transmit byte |
| rx_in_valid | input | 1 | Receive beat offered |
| rx_in_ready | output | 1 | Always 1 |
| rx_in_data | input | 8 | Receive slot byte |
| rx_in_fas | input | 1 | Receive beat is slot 0 of a frame |
| rx_in_mfas | input | 1 | Receive beat is slot 0 of frame 0 |
| reg_addr | input | 5 | Register address: 0-15 entries, 16 control, 17 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |
| tx_clk_alarm | input | 1 | External alarm that shares the status bit |
| sig_status | output | 1 | Shared status bit |

## Verification
The assertions assume that the transmit source holds its beat while ready is low. They also assume that marker bits are only meaningful on accepted beats and that the register port performs one write at a time. The stimulus drives every input half a cycle away from the sampling edge and raises markers only on beats it completes. It changes the control byte only between beats. It realigns frames and multiframes on purpose at mid-frame positions, so that the counters' resynchronisation rules are exercised within those assumptions.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  localparam int SIG_W = 8;

  typedef struct packed {
    logic       swrst;
    logic [3:0] spare;
    logic       stat_cos;
    logic       ins_en;
    logic       rd_tx;
  } ctrl_t;
endpackage

// File: rtl/e1cas_pos_cnt.sv
module e1cas_pos_cnt #(
  parameter int SLOTS  = 32,
  parameter int FRAMES = 16,
  localparam int SW = $clog2(SLOTS),
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          fas,
  input  logic          mfas,
  output logic [SW-1:0] slot_cur,
  output logic [FW-1:0] frame_cur,
  output logic          mf_last
);
  localparam logic [SW-1:0] SLOT_MAX  = SW'(SLOTS - 1);
  localparam logic [FW-1:0] FRAME_MAX = FW'(FRAMES - 1);

  logic [SW-1:0] slot_q;
  logic [FW-1:0] frame_q;

  function automatic logic [FW-1:0] frame_inc(input logic [FW-1:0] f);
    return (f == FRAME_MAX) ? '0 : f + 1'b1;
  endfunction

  always_comb begin
    slot_cur  = slot_q;
    frame_cur = frame_q;
    if (mfas) begin
      slot_cur  = '0;
      frame_cur = '0;
    end else if (fas) begin
      slot_cur = '0;
      if (slot_q != '0) frame_cur = frame_inc(frame_q);
    end
  end

  assign mf_last = (slot_cur == SLOT_MAX) && (frame_cur == FRAME_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      frame_q <= '0;
    end else if (beat) begin
      if (slot_cur == SLOT_MAX) begin
        slot_q  <= '0;
        frame_q <= frame_inc(frame_cur);
      end else begin
        slot_q  <= slot_cur + 1'b1;
        frame_q <= frame_cur;
      end
    end
  end
endmodule

// File: rtl/e1cas_tx_store.sv
module e1cas_tx_store #(
  parameter int FRAMES = 16,
  parameter int DW     = 8,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [FW-1:0] ins_idx,
  output logic [DW-1:0] ins_data,
  input  logic [FW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] ent [FRAMES];

  for (genvar i = 0; i < FRAMES; i++) begin : g_ent
    // entry 0 holds the alignment nibble only; its upper half stays zero
    localparam logic [DW-1:0] KEEP =
      (i == 0) ? {{(DW - DW/2){1'b0}}, {(DW/2){1'b1}}} : {DW{1'b1}};
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (clr)                            q <= '0;
      else if (wr_en && wr_idx == FW'(i))      q <= wr_data & KEEP;
    end
    assign ent[i] = q;
  end

  assign ins_data = ent[ins_idx];
  assign rd_data  = ent[rd_idx];
endmodule

// File: rtl/e1cas_rx_capture.sv
module e1cas_rx_capture #(
  parameter int FRAMES = 16,
  parameter int DW     = 8,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_en,
  input  logic [FW-1:0] cap_idx,
  input  logic [DW-1:0] cap_data,
  input  logic          mf_end,
  input  logic          cos_clr,
  input  logic [FW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          cos
);
  logic [DW-1:0] ent [FRAMES];
  logic          acc_q, acc_n, diff;

  for (genvar i = 0; i < FRAMES; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= '0;
      else if (clr)                         q <= '0;
      else if (cap_en && cap_idx == FW'(i)) q <= cap_data;
    end
    assign ent[i] = q;
  end

  // frame 0 carries alignment, not signaling, so it is left out of the compare
  assign diff    = cap_en && (cap_idx != '0) && (cap_data != ent[cap_idx]);
  assign acc_n   = acc_q | diff;
  assign rd_data = ent[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      cos   <= 1'b0;
    end else if (clr) begin
      acc_q <= 1'b0;
      cos   <= 1'b0;
    end else begin
      acc_q <= mf_end ? 1'b0 : acc_n;
      cos   <= (cos & ~cos_clr) | (mf_end & acc_n);
    end
  end
endmodule

// File: rtl/e1cas_engine.sv
module e1cas_engine
  import e1cas_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int FRAMES   = 16,
  parameter int SIG_SLOT = 16,
  localparam int AW = $clog2(FRAMES) + 1,
  localparam int DW = SIG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  input  logic          tx_in_fas,
  input  logic          tx_in_mfas,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  input  logic          rx_in_fas,
  input  logic          rx_in_mfas,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tx_clk_alarm,
  output logic          sig_status
);
  localparam int SW = $clog2(SLOTS);
  localparam int FW = $clog2(FRAMES);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(FRAMES);
  localparam logic [AW-1:0] STAT_ADDR = AW'(FRAMES + 1);
  localparam logic [SW-1:0] SIG_POS   = SW'(SIG_SLOT);

  ctrl_t         ctrl_q;
  logic          tx_beat, rx_beat, rx_last, tx_last;
  logic [SW-1:0] tx_slot, rx_slot;
  logic [FW-1:0] tx_frame, rx_frame;
  logic [DW-1:0] ins_byte, tx_rd, rx_rd;
  logic          sa_hit, soft_fire, cos_flag, cos_clr;

  assign tx_in_ready  = tx_out_ready;
  assign tx_out_valid = tx_in_valid;
  assign rx_in_ready  = 1'b1;
  assign tx_beat      = tx_in_valid & tx_out_ready;
  assign rx_beat      = rx_in_valid;

  assign sa_hit    = reg_addr < AW'(FRAMES);
  assign soft_fire = reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[DW-1] && !ctrl_q.swrst;
  assign cos_clr   = reg_wr && (reg_addr == STAT_ADDR) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (soft_fire) ctrl_q <= '0;
    else if (reg_wr && reg_addr == CTRL_ADDR)
      ctrl_q <= '{swrst: 1'b0, spare: 4'b0, stat_cos: reg_wdata[2],
                  ins_en: reg_wdata[1], rd_tx: reg_wdata[0]};
  end

  e1cas_pos_cnt #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_tx_pos (
    .clk, .rst_n, .beat(tx_beat), .fas(tx_in_fas), .mfas(tx_in_mfas),
    .slot_cur(tx_slot), .frame_cur(tx_frame), .mf_last(tx_last));

  e1cas_pos_cnt #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_rx_pos (
    .clk, .rst_n, .beat(rx_beat), .fas(rx_in_fas), .mfas(rx_in_mfas),
    .slot_cur(rx_slot), .frame_cur(rx_frame), .mf_last(rx_last));

  e1cas_tx_store #(.FRAMES(FRAMES), .DW(DW)) u_tx_store (
    .clk, .rst_n, .clr(soft_fire),
    .wr_en(reg_wr && sa_hit), .wr_idx(reg_addr[FW-1:0]), .wr_data(reg_wdata),
    .ins_idx(tx_frame), .ins_data(ins_byte),
    .rd_idx(reg_addr[FW-1:0]), .rd_data(tx_rd));

  e1cas_rx_capture #(.FRAMES(FRAMES), .DW(DW)) u_rx_cap (
    .clk, .rst_n, .clr(soft_fire),
    .cap_en(rx_beat && rx_slot == SIG_POS), .cap_idx(rx_frame), .cap_data(rx_in_data),
    .mf_end(rx_beat && rx_last), .cos_clr(cos_clr),
    .rd_idx(reg_addr[FW-1:0]), .rd_data(rx_rd), .cos(cos_flag));

  assign tx_out_data = (ctrl_q.ins_en && tx_slot == SIG_POS) ? ins_byte : tx_in_data;
  assign sig_status  = ctrl_q.stat_cos ? cos_flag : tx_clk_alarm;

  always_comb begin
    reg_rdata = '0;
    if (sa_hit)                      reg_rdata = ctrl_q.rd_tx ? tx_rd : rx_rd;
    else if (reg_addr == CTRL_ADDR)  reg_rdata = ctrl_q;
    else if (reg_addr == STAT_ADDR)  reg_rdata = {{(DW-1){1'b0}}, sig_status};
  end

  logic unused_tx_last;
  assign unused_tx_last = tx_last;
endmodule

// File: rtl/e1cas_checker.sv
module e1cas_checker #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_in_valid,
  input logic          tx_in_ready,
  input logic [DW-1:0] tx_in_data,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [DW-1:0] tx_out_data,
  input logic          rx_in_ready,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] ctrl_byte,
  input logic          soft_fire,
  input logic          cos_flag,
  input logic          rx_beat,
  input logic          rx_last
);
  p_handshake_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_ready == tx_out_ready) && (tx_out_valid == tx_in_valid) && rx_in_ready);

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_byte[1] && tx_in_valid) |-> (tx_out_data == tx_in_data));

  p_entry0_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_byte[0] && reg_addr == '0) |-> (reg_rdata[DW-1:DW/2] == '0));

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_fire |=> (ctrl_byte == '0) && !cos_flag);

  p_cos_at_mf_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cos_flag) |-> $past(rx_beat && rx_last));
endmodule

bind e1cas_engine e1cas_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
  .rx_in_ready(rx_in_ready), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .ctrl_byte(ctrl_q), .soft_fire(soft_fire), .cos_flag(cos_flag),
  .rx_beat(rx_beat), .rx_last(rx_last));

// File: tb/test_e1cas_engine.sv
`timescale 1ns/1ps
module test_e1cas_engine;
  logic       clk = 0, rst_n = 0;
  logic       tx_in_valid = 0, tx_in_fas = 0, tx_in_mfas = 0, tx_out_ready = 1;
  logic [7:0] tx_in_data = 0;
  logic       tx_in_ready, tx_out_valid;
  logic [7:0] tx_out_data;
  logic       rx_in_valid = 0, rx_in_fas = 0, rx_in_mfas = 0, rx_in_ready;
  logic [7:0] rx_in_data = 0;
  logic [4:0] reg_addr = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       tx_clk_alarm = 0, sig_status;

  int checks = 0, failures = 0;
  int mf = 0, ms = 0;
  bit ins_on = 0, done = 0;
  logic [7:0] exp_tx [16];
  logic [7:0] rx_sig [16];
  logic [7:0] rd;

  always #2 clk = ~clk;

  e1cas_engine i_e1cas_engine (.*);

  // {addr, wdata, expected readback}
  localparam logic [23:0] WVEC [8] = '{
    {8'd0,  8'hFF, 8'h0F}, {8'd1,  8'hA5, 8'hA5}, {8'd5,  8'h3C, 8'h3C},
    {8'd15, 8'h81, 8'h81}, {8'd0,  8'h5A, 8'h0A}, {8'd8,  8'h00, 8'h00},
    {8'd15, 8'h7E, 8'h7E}, {8'd3,  8'hC3, 8'hC3}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
    if (a < 16) exp_tx[a] = (a == 0) ? (d & 8'h0F) : d;
    if (a == 16) begin
      ins_on = d[1];
      if (d[7]) begin ins_on = 0; foreach (exp_tx[i]) exp_tx[i] = 0; end
    end
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic tx_send(input logic [7:0] d, input logic fas, input logic mfas, input string req);
    logic [7:0] e;
    if (mfas) begin mf = 0; ms = 0; end
    else if (fas) begin if (ms != 0) mf = (mf + 1) % 16; ms = 0; end
    e = (ins_on && ms == 16) ? exp_tx[mf] : d;
    @(negedge clk); tx_in_valid = 1; tx_in_data = d; tx_in_fas = fas; tx_in_mfas = mfas;
    #1 chk(req, tx_out_data, e);
    @(posedge clk); #1 tx_in_valid = 0; tx_in_fas = 0; tx_in_mfas = 0;
    if (ms == 31) begin ms = 0; mf = (mf + 1) % 16; end else ms++;
  endtask

  task automatic tx_mf(input string req);
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 32; s++)
        tx_send(8'(s * 5 + f * 3), s == 0, f == 0 && s == 0, req);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic fas, input logic mfas);
    @(negedge clk); rx_in_valid = 1; rx_in_data = d; rx_in_fas = fas; rx_in_mfas = mfas;
    @(posedge clk); #1 rx_in_valid = 0; rx_in_fas = 0; rx_in_mfas = 0;
  endtask

  task automatic rx_mf(input bit stop_early);
    for (int f = 0; f < 16; f++)
      for (int s = 0; s < 32; s++)
        if (!(stop_early && f == 15 && s == 31))
          rx_send((s == 16) ? rx_sig[f] : 8'(8'hE5 ^ s), s == 0, f == 0 && s == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog expired act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    foreach (exp_tx[i]) exp_tx[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    reg_read(16, rd); chk("R11 reset ctrl", rd, 0);
    reg_read(5, rd);  chk("R11 reset rx entry", rd, 0);
    chk("R12 ready follow", tx_in_ready, tx_out_ready);
    chk("R12 rx ready", rx_in_ready, 1);

    // table of writes and readbacks
    reg_write(16, 8'h01);
    foreach (WVEC[i]) begin
      reg_write(WVEC[i][20:16], WVEC[i][15:8]);
      reg_read(WVEC[i][20:16], rd);
      chk((WVEC[i][23:16] == 0) ? "R2 entry0 nibble" : "R1 tx readback", rd, WVEC[i][7:0]);
    end

    // write with rx read select still goes to tx
    reg_write(16, 8'h00);
    reg_write(4, 8'h99);
    reg_read(4, rd); chk("R1 R3 rx untouched by write", rd, 0);
    reg_write(16, 8'h01);
    reg_read(4, rd); chk("R1 write hit tx", rd, 8'h99);

    // insertion on and off
    reg_write(1, 8'hA5);
    reg_write(16, 8'h03);
    tx_mf("R4 insert");
    reg_write(16, 8'h01);
    tx_mf("R5 bypass");

    // back-pressure stall at slot 16
    reg_write(16, 8'h03);
    tx_send(8'h10, 1, 1, "R12 pre-stall");
    for (int s = 1; s < 16; s++) tx_send(8'(s), 0, 0, "R12 pre-stall");
    @(negedge clk); tx_in_valid = 1; tx_in_data = 8'h77; tx_out_ready = 0;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R12 stall ready", tx_in_ready, 0);
      chk("R4 stalled insert", tx_out_data, exp_tx[0]);
      @(negedge clk);
    end
    tx_out_ready = 1;
    @(posedge clk); #1 tx_in_valid = 0;
    ms = 17;
    for (int s = 17; s < 32; s++) tx_send(8'(s), 0, 0, "R12 post-stall");
    for (int s = 0; s < 17; s++) tx_send(8'(s + 40), s == 0, 0, "R12 R6 held position");

    // realignment
    for (int s = 0; s < 5; s++) tx_send(8'(s + 90), 0, 0, "R6 drift");
    tx_send(8'h21, 0, 1, "R6 mf realign");
    for (int s = 1; s < 17; s++) tx_send(8'(s + 60), 0, 0, "R6 mf realign");
    tx_send(8'h22, 1, 0, "R6 frame realign");
    for (int s = 1; s < 17; s++) tx_send(8'(s + 70), 0, 0, "R6 frame realign");
    chk("R6 slot after realign", ms, 17);
    chk("R6 frame after realign", mf, 1);

    // receive capture and change flag
    reg_write(16, 8'h00);
    for (int f = 0; f < 16; f++) rx_sig[f] = (f == 0) ? 8'h0B : 8'(8'h11 * f);
    rx_mf(0);
    for (int f = 0; f < 16; f++) begin
      reg_read(5'(f), rd); chk("R7 R3 rx entry", rd, rx_sig[f]);
    end
    tx_clk_alarm = 1;
    reg_read(17, rd); chk("R9 alarm shown", rd[0], 1);
    chk("R9 pin alarm", sig_status, 1);
    tx_clk_alarm = 0;
    reg_read(17, rd); chk("R9 alarm low", rd[0], 0);
    reg_write(16, 8'h04);
    reg_read(17, rd); chk("R8 first mf change", rd[0], 1);
    chk("R9 pin cos", sig_status, 1);
    reg_write(17, 8'h01);
    reg_read(17, rd); chk("R10 cleared", rd[0], 0);

    rx_mf(0);
    reg_read(17, rd); chk("R8 no change", rd[0], 0);
    rx_sig[0] = 8'h03;
    rx_mf(0);
    reg_read(17, rd); chk("R8 frame0 ignored", rd[0], 0);
    rx_sig[7] = 8'h5C;
    rx_mf(1);
    reg_read(17, rd); chk("R8 not before mf end", rd[0], 0);
    rx_send(8'hE5 ^ 8'd31, 0, 0);
    reg_read(17, rd); chk("R8 set at mf end", rd[0], 1);
    reg_read(7, rd);  chk("R7 changed entry", rd, 8'h5C);

    // software reset
    reg_write(16, 8'h87);
    reg_read(16, rd); chk("R11 ctrl cleared", rd, 0);
    reg_read(7, rd);  chk("R11 rx cleared", rd, 0);
    reg_write(16, 8'h05);
    reg_read(1, rd);  chk("R11 tx cleared", rd, 0);
    reg_read(17, rd); chk("R11 cos cleared", rd[0], 0);
    reg_write(16, 8'h00);
    tx_send(8'h44, 1, 1, "R5 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule